// File: doc/BRIEF.md
# MSI Coherence Directory

This block is the home-node directory for a few memory blocks shared by several caches. It follows an MSI protocol. For every block it keeps a protocol state, a bit vector of the caches that hold the block read-only, and the identity of the single cache that holds it writable. It also acts as the memory front end, so it issues the reads and write-backs to the memory port.

It has three input channels: coherence requests from caches, data answers that an owner sends back after a forward, and memory responses. It has three output channels. The forward channel carries forwarded requests, invalidations and put acknowledgements. The response channel carries data with an ack count. The memory command channel carries reads and writes.

Every channel uses a valid/ready handshake. Each output is one register deep, and the block takes a message only when every output that the message needs is empty. At most one input message is taken per cycle. When several inputs are valid, memory responses win, then cache data answers, then requests. A GetS or GetM that reaches a block in a transient state is left at the head of the request channel and is not accepted.

Top module: `coh_dir`

## Requirements
- R1: After reset every block is Invalid with no sharers and no owner, and no output channel is valid. A first GetS to any block therefore causes a memory read (command write bit 0) for that block.
- R2: A GetS (request code 0) in Invalid or Shared reads memory, adds the requester to the sharers and waits. The memory read data (memory kind 0) goes to the requester with ack count 0, and the block becomes Shared.
- R3: A GetM (request code 1) in Invalid reads memory and records the requester as owner. The returned data goes to the requester with an ack count equal to the number of sharers still recorded, which is 0 here, and the block becomes Modified.
- R4: A GetM in Shared reads memory, removes the requester from the sharers and records it as owner. If any sharers remain, one invalidation (forward code 2) goes out with a destination mask of exactly those sharers; if none remain, no invalidation is sent. The data reply carries the count of those sharers, and the sharer vector is then cleared.
- R5: A GetS in Modified sends a forwarded GetS (forward code 0) to the owner and makes both the requester and the old owner sharers. The owner's data answer is written to memory (write bit 1). The memory write-ack (kind 1) then returns the block to Shared.
- R6: A GetM in Modified sends a forwarded GetM (forward code 1) to the old owner, which carries the new requester ID. The requester becomes owner and the block stays Modified.
- R7: A PutM (request code 3) from the owner in Modified writes the carried data to memory, sends a put-ack (forward code 3) to the owner and clears the owner. The write-ack then moves the block to Invalid.
- R8: A PutS (request code 2) counts as last when the block has exactly one sharer and that sharer is the requester. A last PutS in Shared removes the requester, acknowledges it and moves the block to Invalid. A PutS that is not last only removes the requester and acknowledges it.
- R9: Stale puts are always acknowledged and never reach memory. A PutS or a non-owner PutM in Invalid or Modified changes no state.
- R10: Within one cycle the memory response is accepted ahead of a cache data answer, and a cache data answer ahead of a request. A cache data answer that arrives outside the owner-data wait state is consumed and has no effect.
- R11: A GetS or GetM that reaches a block waiting on memory or on owner data is not accepted (ready stays low), and no output is produced for it. An output message, once valid, stays unchanged until it is taken.
- R12: A block that enters Modified has exactly one owner and no sharers. A block that enters Invalid has neither an owner nor any sharers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_type | input | 2 | 0 GetS, 1 GetM, 2 PutS, 3 PutM |
| req_src | input | IDW | Requesting cache |
| req_blk | input | BW | Block index |
| req_data | input | DW | Write-back data for PutM |
| cresp_valid | input | 1 | Owner data answer valid |
| cresp_ready | output | 1 | Owner data answer accepted |
| cresp_blk | input | BW | Block of the data answer |
| cresp_data | input | DW | Owner data |
| mresp_valid | input | 1 | Memory response valid |
| mresp_ready | output | 1 | Memory response accepted |
| mresp_kind | input | 1 | 0 read data, 1 write ack |
| mresp_blk | input | BW | Block of the memory response |
| mresp_data | input | DW | Read data |
| mcmd_valid | output | 1 | Memory command valid |
| mcmd_ready | input | 1 | Memory command taken |
| mcmd_write | output | 1 | 1 write, 0 read |
| mcmd_blk | output | BW | Block addressed |
| mcmd_data | output | DW | Write data |
| fwd_valid | output | 1 | Forward message valid |
| fwd_ready | input | 1 | Forward message taken |
| fwd_type | output | 2 | 0 fwd GetS, 1 fwd GetM, 2 invalidate, 3 put-ack |
| fwd_dest | output | NCACHE | Destination cache mask |
| fwd_req | output | IDW | Original requester |
| fwd_blk | output | BW | Block |
| rsp_valid | output | 1 | Data response valid |
| rsp_ready | input | 1 | Data response taken |
| rsp_dest | output | IDW | Receiving cache |
| rsp_blk | output | BW | Block |
| rsp_data | output | DW | Data |
| rsp_acks | output | AW | Invalidation acks the receiver must collect |

## Verification
The bench sweeps every block from reset through a first read. It then drives one block through each stable and transient state in turn, using data values from which every reply can be predicted. It probes the following cases:
- GetM in Shared where the requester is the only sharer. A design that always sends the invalidation would emit one with an empty mask.
- The ack count after the sharers are cleared. A design that leaves stale sharers in place would report a nonzero count on a later GetM.
- A PutM from a cache that is not the owner. A design that misclassifies it would write stale data to memory.
- A memory response that collides with a request. A design with the wrong priority would accept the request first.
- Requests that arrive in transient states. A design that lets them through would corrupt the pending requester.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [2:0] {
    ST_I, ST_S, ST_M, ST_SD, ST_SM, ST_MM, ST_MIM, ST_SSM
  } dstate_t;

  localparam logic [1:0] RQ_GETS = 2'd0;
  localparam logic [1:0] RQ_GETM = 2'd1;
  localparam logic [1:0] RQ_PUTS = 2'd2;
  localparam logic [1:0] RQ_PUTM = 2'd3;

  localparam logic [1:0] FW_GETS = 2'd0;
  localparam logic [1:0] FW_GETM = 2'd1;
  localparam logic [1:0] FW_INV  = 2'd2;
  localparam logic [1:0] FW_PACK = 2'd3;

  localparam logic MR_DATA = 1'b0;
  localparam logic MR_ACK  = 1'b1;
endpackage

// File: rtl/coh_dir_count.sv
// Sharer population count and owner match for one directory entry.
module coh_dir_count #(
  parameter int NCACHE = 4,
  parameter int IDW    = 2,
  parameter int AW     = 3
) (
  input  logic [NCACHE-1:0] sh,
  input  logic              ov,
  input  logic [IDW-1:0]    ow,
  input  logic [IDW-1:0]    who,
  output logic [AW-1:0]     cnt,
  output logic              hit
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < NCACHE; i++) cnt = cnt + AW'(sh[i]);
  end
  assign hit = ov && (ow == who);
endmodule

// File: rtl/coh_dir_oreg.sv
// One-deep output holding register with valid/ready drain.
module coh_dir_oreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/coh_dir.sv
module coh_dir
  import coh_dir_pkg::*;
#(
  parameter int NCACHE = 4,
  parameter int NBLK   = 4,
  parameter int DW     = 8,
  localparam int IDW   = $clog2(NCACHE),
  localparam int BW    = $clog2(NBLK),
  localparam int AW    = $clog2(NCACHE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [IDW-1:0]    req_src,
  input  logic [BW-1:0]     req_blk,
  input  logic [DW-1:0]     req_data,
  input  logic              cresp_valid,
  output logic              cresp_ready,
  input  logic [BW-1:0]     cresp_blk,
  input  logic [DW-1:0]     cresp_data,
  input  logic              mresp_valid,
  output logic              mresp_ready,
  input  logic              mresp_kind,
  input  logic [BW-1:0]     mresp_blk,
  input  logic [DW-1:0]     mresp_data,
  output logic              mcmd_valid,
  input  logic              mcmd_ready,
  output logic              mcmd_write,
  output logic [BW-1:0]     mcmd_blk,
  output logic [DW-1:0]     mcmd_data,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [1:0]        fwd_type,
  output logic [NCACHE-1:0] fwd_dest,
  output logic [IDW-1:0]    fwd_req,
  output logic [BW-1:0]     fwd_blk,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [IDW-1:0]    rsp_dest,
  output logic [BW-1:0]     rsp_blk,
  output logic [DW-1:0]     rsp_data,
  output logic [AW-1:0]     rsp_acks
);
  localparam int FW_W = 2 + NCACHE + IDW + BW;
  localparam int RS_W = IDW + BW + DW + AW;
  localparam int MC_W = 1 + BW + DW;

  // directory table
  dstate_t           st_q [NBLK];
  logic [NCACHE-1:0] sh_q [NBLK];
  logic [IDW-1:0]    ow_q [NBLK];
  logic [IDW-1:0]    pd_q [NBLK];
  logic              ov_q [NBLK];

  // next-entry write port
  logic              wr_en;
  logic [BW-1:0]     wr_blk;
  dstate_t           w_st;
  logic [NCACHE-1:0] w_sh;
  logic [IDW-1:0]    w_ow, w_pd;
  logic              w_ov;

  // output staging
  logic            ld_f, ld_r, ld_m;
  logic [1:0]        f_type;
  logic [NCACHE-1:0] f_dest;
  logic [FW_W-1:0] f_q;
  logic [RS_W-1:0] r_q;
  logic [MC_W-1:0] m_q;
  logic            m_wr;
  logic [BW-1:0]   m_blk;
  logic [DW-1:0]   m_data;
  logic            fwd_free, rsp_free, mcmd_free;

  // per-channel entry views
  dstate_t           q_st, m_st, c_st;
  logic [NCACHE-1:0] q_sh, m_sh, c_sh, q_bit, ow_bit;
  logic [IDW-1:0]    q_ow, m_ow, c_ow, q_pd, m_pd, c_pd;
  logic              q_ov, m_ov, c_ov, q_hit, m_hit, q_last;
  logic [AW-1:0]     q_cnt, m_cnt;

  assign q_st = st_q[req_blk];   assign q_sh = sh_q[req_blk];
  assign q_ow = ow_q[req_blk];   assign q_ov = ov_q[req_blk];
  assign q_pd = pd_q[req_blk];
  assign m_st = st_q[mresp_blk]; assign m_sh = sh_q[mresp_blk];
  assign m_ow = ow_q[mresp_blk]; assign m_ov = ov_q[mresp_blk];
  assign m_pd = pd_q[mresp_blk];
  assign c_st = st_q[cresp_blk]; assign c_sh = sh_q[cresp_blk];
  assign c_ow = ow_q[cresp_blk]; assign c_ov = ov_q[cresp_blk];
  assign c_pd = pd_q[cresp_blk];

  assign q_bit  = NCACHE'(1) << req_src;
  assign ow_bit = NCACHE'(1) << q_ow;

  coh_dir_count #(.NCACHE(NCACHE), .IDW(IDW), .AW(AW)) u_qcnt (
    .sh(q_sh), .ov(q_ov), .ow(q_ow), .who(req_src), .cnt(q_cnt), .hit(q_hit));
  coh_dir_count #(.NCACHE(NCACHE), .IDW(IDW), .AW(AW)) u_mcnt (
    .sh(m_sh), .ov(m_ov), .ow(m_ow), .who(m_pd), .cnt(m_cnt), .hit(m_hit));

  assign q_last = (q_cnt == AW'(1)) && q_sh[req_src];

  assign fwd_free  = !fwd_valid;
  assign rsp_free  = !rsp_valid;
  assign mcmd_free = !mcmd_valid;

  always_comb begin
    mresp_ready = 1'b0; cresp_ready = 1'b0; req_ready = 1'b0;
    wr_en = 1'b0; wr_blk = req_blk;
    w_st = q_st; w_sh = q_sh; w_ow = q_ow; w_ov = q_ov; w_pd = q_pd;
    ld_f = 1'b0; f_type = FW_PACK; f_dest = q_bit;
    ld_r = 1'b0;
    ld_m = 1'b0; m_wr = 1'b0; m_blk = req_blk; m_data = req_data;
    if (mresp_valid && (mresp_kind == MR_ACK || rsp_free)) begin
      mresp_ready = 1'b1; wr_en = 1'b1; wr_blk = mresp_blk;
      w_st = m_st; w_sh = m_sh; w_ow = m_ow; w_ov = m_ov; w_pd = m_pd;
      if (mresp_kind == MR_ACK) begin
        if (m_st == ST_MIM)      w_st = ST_I;
        else if (m_st == ST_SSM) w_st = ST_S;
      end else begin
        ld_r = 1'b1;
        if (m_st == ST_SM) w_st = ST_S;
        else if (m_st == ST_MM) begin
          w_st = ST_M;
          w_sh = '0;
        end
      end
    end else if (cresp_valid && mcmd_free) begin
      cresp_ready = 1'b1;
      if (c_st == ST_SD) begin
        wr_en = 1'b1; wr_blk = cresp_blk;
        w_st = ST_SSM; w_sh = c_sh; w_ow = c_ow; w_ov = c_ov; w_pd = c_pd;
        ld_m = 1'b1; m_wr = 1'b1; m_blk = cresp_blk; m_data = cresp_data;
      end
    end else if (req_valid) begin
      unique case (req_type)
        RQ_GETS: begin
          if ((q_st == ST_I || q_st == ST_S) && mcmd_free) begin
            req_ready = 1'b1; wr_en = 1'b1; ld_m = 1'b1;
            w_sh = q_sh | q_bit; w_pd = req_src; w_st = ST_SM;
          end else if (q_st == ST_M && fwd_free) begin
            req_ready = 1'b1; wr_en = 1'b1; ld_f = 1'b1;
            f_type = FW_GETS; f_dest = ow_bit;
            w_sh = q_bit | ow_bit; w_ov = 1'b0; w_st = ST_SD;
          end
        end
        RQ_GETM: begin
          if ((q_st == ST_I && mcmd_free) ||
              (q_st == ST_S && mcmd_free && fwd_free)) begin
            req_ready = 1'b1; wr_en = 1'b1; ld_m = 1'b1;
            w_ow = req_src; w_ov = 1'b1; w_pd = req_src; w_st = ST_MM;
            if (q_st == ST_S) begin
              w_sh   = q_sh & ~q_bit;
              ld_f   = (w_sh != '0);
              f_type = FW_INV;
              f_dest = w_sh;
            end
          end else if (q_st == ST_M && fwd_free) begin
            req_ready = 1'b1; wr_en = 1'b1; ld_f = 1'b1;
            f_type = FW_GETM; f_dest = ow_bit; w_ow = req_src;
          end
        end
        default: begin
          if (fwd_free && (mcmd_free || !(req_type == RQ_PUTM && q_hit && q_st == ST_M))) begin
            req_ready = 1'b1; wr_en = 1'b1; ld_f = 1'b1;
            if (req_type == RQ_PUTM && q_hit && q_st == ST_M) begin
              ld_m = 1'b1; m_wr = 1'b1; w_ov = 1'b0; w_st = ST_MIM;
            end else if (q_st == ST_S || q_st == ST_SD || q_st == ST_SM || q_st == ST_SSM) begin
              w_sh = q_sh & ~q_bit;
              if (req_type == RQ_PUTS && q_last && q_st == ST_S) w_st = ST_I;
            end
          end
        end
      endcase
    end
  end

  generate
    for (genvar b = 0; b < NBLK; b++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q[b] <= ST_I;
          sh_q[b] <= '0;
          ow_q[b] <= '0;
          ov_q[b] <= 1'b0;
          pd_q[b] <= '0;
        end else if (wr_en && wr_blk == BW'(b)) begin
          st_q[b] <= w_st;
          sh_q[b] <= w_sh;
          ow_q[b] <= w_ow;
          ov_q[b] <= w_ov;
          pd_q[b] <= w_pd;
        end
      end
    end
  endgenerate

  coh_dir_oreg #(.W(FW_W)) u_fwd (
    .clk(clk), .rst_n(rst_n), .load(ld_f),
    .din({f_type, f_dest, req_src, req_blk}),
    .ready(fwd_ready), .valid(fwd_valid), .dout(f_q));
  coh_dir_oreg #(.W(RS_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .load(ld_r),
    .din({m_pd, mresp_blk, mresp_data, m_hit ? m_cnt : AW'(0)}),
    .ready(rsp_ready), .valid(rsp_valid), .dout(r_q));
  coh_dir_oreg #(.W(MC_W)) u_mcmd (
    .clk(clk), .rst_n(rst_n), .load(ld_m),
    .din({m_wr, m_blk, m_data}),
    .ready(mcmd_ready), .valid(mcmd_valid), .dout(m_q));

  assign {fwd_type, fwd_dest, fwd_req, fwd_blk}  = f_q;
  assign {rsp_dest, rsp_blk, rsp_data, rsp_acks} = r_q;
  assign {mcmd_write, mcmd_blk, mcmd_data}       = m_q;

  // flattened views of the table for the bound checker
  logic [NBLK*3-1:0]      st_flat;
  logic [NBLK*NCACHE-1:0] sh_flat;
  logic [NBLK-1:0]        ov_flat;
  generate
    for (genvar b = 0; b < NBLK; b++) begin : g_flat
      assign st_flat[b*3 +: 3]           = st_q[b];
      assign sh_flat[b*NCACHE +: NCACHE] = sh_q[b];
      assign ov_flat[b]                  = ov_q[b];
    end
  endgenerate
endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk
  import coh_dir_pkg::*;
#(
  parameter int NCACHE = 4,
  parameter int NBLK   = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mresp_valid,
  input logic                   mresp_ready,
  input logic                   rsp_valid,
  input logic                   fwd_valid,
  input logic                   fwd_ready,
  input logic [1:0]             fwd_type,
  input logic [NCACHE-1:0]      fwd_dest,
  input logic [NBLK*3-1:0]      st_flat,
  input logic [NBLK*NCACHE-1:0] sh_flat,
  input logic [NBLK-1:0]        ov_flat
);
  assert_mem_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mresp_valid && !rsp_valid) |-> mresp_ready);

  assert_fwd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_type) && $stable(fwd_dest)));

  assert_fwd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_type != FW_INV) |-> ($countones(fwd_dest) == 1));

  assert_inv_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_type == FW_INV) |-> (fwd_dest != '0));

  generate
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
      assert_m_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_flat[b*3 +: 3] == 3'(ST_M)) |-> (ov_flat[b] && sh_flat[b*NCACHE +: NCACHE] == '0));
      assert_i_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_flat[b*3 +: 3] == 3'(ST_I)) |-> (!ov_flat[b] && sh_flat[b*NCACHE +: NCACHE] == '0));
    end
  endgenerate
endmodule

bind coh_dir coh_dir_chk #(.NCACHE(NCACHE), .NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .mresp_valid(mresp_valid), .mresp_ready(mresp_ready),
  .rsp_valid(rsp_valid), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
  .fwd_type(fwd_type), .fwd_dest(fwd_dest), .st_flat(st_flat),
  .sh_flat(sh_flat), .ov_flat(ov_flat));

// File: tb/sim_coh_dir.sv
module sim_coh_dir;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  logic clk, rst_n;
  logic req_valid, req_ready; logic [1:0] req_type; logic [1:0] req_src, req_blk; logic [7:0] req_data;
  logic cresp_valid, cresp_ready; logic [1:0] cresp_blk; logic [7:0] cresp_data;
  logic mresp_valid, mresp_ready, mresp_kind; logic [1:0] mresp_blk; logic [7:0] mresp_data;
  logic mcmd_valid, mcmd_ready, mcmd_write; logic [1:0] mcmd_blk; logic [7:0] mcmd_data;
  logic fwd_valid, fwd_ready; logic [1:0] fwd_type; logic [3:0] fwd_dest; logic [1:0] fwd_req, fwd_blk;
  logic rsp_valid, rsp_ready; logic [1:0] rsp_dest, rsp_blk; logic [7:0] rsp_data; logic [2:0] rsp_acks;

  coh_dir u0 (.*);

  int nchk = 0, nerr = 0;
  int f_n = 0, f_type = 0, f_dest = 0, f_req = 0;
  int r_n = 0, r_dest = 0, r_data = 0, r_acks = 0;
  int m_n = 0, m_wr = 0, m_blk = 0, m_data = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (fwd_valid && fwd_ready) begin
      f_n <= f_n + 1; f_type <= fwd_type; f_dest <= fwd_dest; f_req <= fwd_req;
    end
    if (rsp_valid && rsp_ready) begin
      r_n <= r_n + 1; r_dest <= rsp_dest; r_data <= rsp_data; r_acks <= rsp_acks;
    end
    if (mcmd_valid && mcmd_ready) begin
      m_n <= m_n + 1; m_wr <= mcmd_write; m_blk <= mcmd_blk; m_data <= mcmd_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ceq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_req();
    bit got = 0;
    for (int i = 0; i < 40 && !got; i++) begin
      #(Q); got = req_ready; @(negedge clk);
    end
    req_valid = 1'b0;
    chk(got, "request accept", 0, 1);
  endtask

  task automatic send_req(input logic [1:0] t, input int src, input int blk, input int d);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_src = 2'(src); req_blk = 2'(blk); req_data = 8'(d);
    wait_req();
    settle();
  endtask

  task automatic stall_req(input logic [1:0] t, input int src, input int blk);
    int fn = f_n, mn = m_n, rn = r_n;
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_src = 2'(src); req_blk = 2'(blk);
    for (int i = 0; i < 3; i++) begin
      #(Q); ceq("R11 stalled request ready", int'(req_ready), 0); @(negedge clk);
    end
    req_valid = 1'b0;
    settle();
    ceq("R11 no output while stalled", f_n + m_n + r_n, fn + mn + rn);
  endtask

  task automatic mem_reply(input logic kind, input int blk, input int d);
    bit got = 0;
    @(negedge clk);
    mresp_valid = 1'b1; mresp_kind = kind; mresp_blk = 2'(blk); mresp_data = 8'(d);
    for (int i = 0; i < 40 && !got; i++) begin
      #(Q); got = mresp_ready; @(negedge clk);
    end
    mresp_valid = 1'b0;
    chk(got, "memory response accept", 0, 1);
    settle();
  endtask

  task automatic owner_data(input int blk, input int d);
    bit got = 0;
    @(negedge clk);
    cresp_valid = 1'b1; cresp_blk = 2'(blk); cresp_data = 8'(d);
    for (int i = 0; i < 40 && !got; i++) begin
      #(Q); got = cresp_ready; @(negedge clk);
    end
    cresp_valid = 1'b0;
    chk(got, "owner data accept", 0, 1);
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int fn, mn;
    rst_n = 1'b0;
    req_valid = 0; req_type = 0; req_src = 0; req_blk = 0; req_data = 0;
    cresp_valid = 0; cresp_blk = 0; cresp_data = 0;
    mresp_valid = 0; mresp_kind = 0; mresp_blk = 0; mresp_data = 0;
    mcmd_ready = 1; fwd_ready = 1; rsp_ready = 1;
    repeat (3) @(negedge clk);
    ceq("R1 outputs idle in reset", int'(fwd_valid) + int'(rsp_valid) + int'(mcmd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    ceq("R1 outputs idle after reset", int'(fwd_valid) + int'(rsp_valid) + int'(mcmd_valid), 0);

    // R1/R2 sweep: every block starts Invalid
    for (int b = 0; b < 4; b++) begin
      mn = m_n;
      send_req(2'd0, 1, b, 0);
      ceq("R1 first GetS reads memory", m_n - mn, 1);
      ceq("R1 read command bit", m_wr, 0);
      ceq("R1 read block", m_blk, b);
      stall_req(2'd1, 2, b);
      mem_reply(1'b0, b, 'hA0 + b);
      ceq("R2 data dest", r_dest, 1);
      ceq("R2 data value", r_data, 'hA0 + b);
      ceq("R2 ack count", r_acks, 0);
    end

    // Block 0: second sharer, then GetM in S
    send_req(2'd0, 2, 0, 0);
    mem_reply(1'b0, 0, 'hA8);
    ceq("R2 shared read dest", r_dest, 2);
    fn = f_n;
    send_req(2'd1, 3, 0, 0);
    ceq("R4 one invalidation", f_n - fn, 1);
    ceq("R4 invalidation code", f_type, 2);
    ceq("R4 invalidation mask", f_dest, 'b0110);
    ceq("R4 invalidation requester", f_req, 3);
    mem_reply(1'b0, 0, 'hB0);
    ceq("R4 data dest", r_dest, 3);
    ceq("R4 ack count", r_acks, 2);

    // GetS in M
    send_req(2'd0, 0, 0, 0);
    ceq("R5 forward code", f_type, 0);
    ceq("R5 forward to owner", f_dest, 'b1000);
    ceq("R5 forward requester", f_req, 0);
    stall_req(2'd1, 1, 0);
    owner_data(0, 'h55);
    ceq("R5 memory write bit", m_wr, 1);
    ceq("R5 memory write data", m_data, 'h55);
    stall_req(2'd0, 2, 0);
    mem_reply(1'b1, 0, 0);
    send_req(2'd2, 0, 0, 0);
    ceq("R8 not-last PutS ack code", f_type, 3);
    ceq("R8 not-last PutS ack dest", f_dest, 'b0001);
    send_req(2'd2, 3, 0, 0);
    ceq("R8 last PutS ack dest", f_dest, 'b1000);
    fn = f_n; mn = m_n;
    send_req(2'd1, 2, 0, 0);
    ceq("R8 block Invalid after last PutS, no invalidation", f_n - fn, 0);
    ceq("R3 GetM in I reads memory", m_n - mn, 1);
    mem_reply(1'b0, 0, 'hC0);
    ceq("R3 data dest", r_dest, 2);
    ceq("R12 ack count after clear", r_acks, 0);

    // GetM in M, stale PutM, owner PutM
    send_req(2'd1, 1, 0, 0);
    ceq("R6 forward code", f_type, 1);
    ceq("R6 forward to old owner", f_dest, 'b0100);
    ceq("R6 forward requester", f_req, 1);
    mn = m_n;
    send_req(2'd3, 2, 0, 'h66);
    ceq("R9 stale PutM ack dest", f_dest, 'b0100);
    ceq("R9 stale PutM no memory", m_n - mn, 0);
    send_req(2'd3, 1, 0, 'h77);
    ceq("R7 write-back count", m_n - mn, 1);
    ceq("R7 write-back data", m_data, 'h77);
    ceq("R7 write bit", m_wr, 1);
    ceq("R7 put-ack dest", f_dest, 'b0010);
    stall_req(2'd0, 3, 0);
    mem_reply(1'b1, 0, 0);
    mn = m_n;
    send_req(2'd0, 0, 0, 0);
    ceq("R7 block Invalid after write-ack", m_n - mn, 1);
    ceq("R7 read bit", m_wr, 0);
    mem_reply(1'b0, 0, 'hC1);

    // Priority: memory response vs request (block1 in S_m, request on block3)
    send_req(2'd0, 2, 1, 0);
    @(negedge clk);
    mresp_valid = 1; mresp_kind = 0; mresp_blk = 1; mresp_data = 'hD1;
    req_valid = 1; req_type = 2'd2; req_src = 3; req_blk = 3;
    #(Q);
    ceq("R10 memory response first", int'(mresp_ready), 1);
    ceq("R10 request held back", int'(req_ready), 0);
    @(negedge clk);
    mresp_valid = 0;
    wait_req();
    settle();
    ceq("R10 read data dest", r_dest, 2);
    ceq("R10 read data value", r_data, 'hD1);
    ceq("R10 later put-ack dest", f_dest, 'b1000);

    // Priority: cache data vs request; data outside S_D ignored
    mn = m_n;
    @(negedge clk);
    cresp_valid = 1; cresp_blk = 1; cresp_data = 'h99;
    req_valid = 1; req_type = 2'd0; req_src = 0; req_blk = 2;
    #(Q);
    ceq("R10 owner data first", int'(cresp_ready), 1);
    ceq("R10 request held back", int'(req_ready), 0);
    @(negedge clk);
    cresp_valid = 0;
    wait_req();
    settle();
    ceq("R10 stray data no write", m_n - mn, 1);
    ceq("R10 only the read", m_wr, 0);
    mem_reply(1'b0, 2, 'hE2);
    ceq("R2 dest on block 2", r_dest, 0);

    // Stale puts in Invalid on block 2 (sharers 0,1)
    send_req(2'd2, 0, 2, 0);
    send_req(2'd2, 1, 2, 0);
    mn = m_n; fn = f_n;
    send_req(2'd2, 1, 2, 0);
    ceq("R9 stale PutS acked", f_n - fn, 1);
    ceq("R9 stale PutS dest", f_dest, 'b0010);
    ceq("R9 stale PutS no memory", m_n - mn, 0);
    fn = f_n;
    send_req(2'd1, 3, 2, 0);
    ceq("R9 still Invalid, no invalidation", f_n - fn, 0);
    mem_reply(1'b0, 2, 'hE3);
    ceq("R3 acks zero", r_acks, 0);

    // GetM in S by the sole sharer (block 3, sharers {1})
    fn = f_n; mn = m_n;
    send_req(2'd1, 1, 3, 0);
    ceq("R4 empty mask sends no invalidation", f_n - fn, 0);
    ceq("R4 read issued", m_n - mn, 1);
    mem_reply(1'b0, 3, 'hF3);
    ceq("R4 sole sharer acks", r_acks, 0);
    ceq("R4 sole sharer dest", r_dest, 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule